// File: doc/BRIEF.md
# Word-Backed Memory with Atomic Compare-and-Swap

This block is a small on-chip memory whose storage is a column of 64-bit words. A requester presents one operation per cycle: a load, a store, or a 32-bit compare-and-swap (CAS). Loads and stores come in 1, 2, 4 and 8 byte sizes. Every request is checked for natural alignment and for staying inside the configured byte capacity. A request that breaks either rule is answered with a fault and leaves memory alone.

Narrow stores and the CAS read the enclosing 64-bit word, merge their own lane into it and write it back inside the same clock edge. No other request can slip in between the read and the write, so lanes the request does not name keep their contents. The answer appears one cycle after the request. It carries the loaded value, a success flag, the 32-bit value the CAS found in memory, and a fault flag.

A two-state response machine sequences the answers. `ST_IDLE` means no answer is pending. `ST_RESP` means an answer is on the response port this cycle. The machine has four transitions:
- `ST_IDLE` to `ST_RESP` when a request arrives (*accept*).
- `ST_RESP` to `ST_RESP` when another request arrives in the answer cycle (*stream*).
- `ST_RESP` to `ST_IDLE` when no request arrives (*drain*).
- `ST_IDLE` to `ST_IDLE` when there is no traffic (*rest*).

Top module: `word_mem_cas`

## Requirements
- R1: The storage holds ceil(BYTE_CAP/8) 64-bit words. Every word reads as zero after reset.
- R2: Word selection and load data:
  - A request uses word `addr >> 3`.
  - The lane starts at bit `(addr & 7)*8` for a 1-byte access, `(addr & 6)*8` for 2 bytes, `(addr & 4)*8` for 4 bytes, and bit 0 for 8 bytes.
  - A successful load returns its lane zero-extended on `rsp_rdata`, with `rsp_ok`=1 and `rsp_observed`=0.
- R3: A 2, 4 or 8 byte access whose address is not a multiple of its size raises `rsp_fault`. A 1-byte access never faults on alignment.
- R4: A request faults when `addr + size_in_bytes > BYTE_CAP`. This holds even when the bytes lie inside the last, partly used backing word.
- R5: A faulting request returns `rsp_ok`=0, `rsp_rdata`=0 and `rsp_observed`=0. A faulting store leaves memory unchanged.
- R6: A successful store answers `rsp_ok`=1 with `rsp_rdata`=0 and `rsp_observed`=0. It replaces only its own lane and leaves every other byte of the word unchanged.
- R7: When a CAS finds a 32-bit slot value different from `req_expect`, it leaves memory unchanged. It answers `rsp_ok`=0, `rsp_fault`=0, and returns the slot's current value on `rsp_observed`.
- R8: When a CAS finds a slot value equal to `req_expect`, it writes `req_desired` into that slot only. It answers `rsp_ok`=1 with `rsp_observed` equal to `req_expect`.
- R9: A CAS is always a 4-byte access. It ignores `req_size` and faults when its address is not a multiple of 4 or lies out of bounds.
- R10: Timing of answers:
  - `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the fault flag comes in that same cycle.
  - Back-to-back requests each see all writes made by earlier requests.
- R11: Operation code 3 is reserved. It always faults and never writes.

Encodings:
- `req_op`: 0 = load, 1 = store, 2 = CAS, 3 = reserved.
- `req_size`: 0/1/2/3 = 1/2/4/8 bytes.
- Data is little-endian within a word: byte `addr` sits at bit `8*(addr & 7)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code |
| req_size | input | 2 | Log2 of access size in bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, lane value in the low bits |
| req_expect | input | 32 | CAS compare value |
| req_desired | input | 32 | CAS replacement value |
| rsp_valid | output | 1 | Answer present this cycle |
| rsp_rdata | output | 64 | Load result, zero-extended |
| rsp_ok | output | 1 | Request succeeded |
| rsp_observed | output | 32 | Slot value seen by a CAS |
| rsp_fault | output | 1 | Alignment, bounds or opcode fault |

## Verification
The bench uses a 52-byte capacity, so the last backing word is only half usable. A design that bounds-checks whole words would then accept bytes 52..55 instead of faulting them.

Every size is swept over every address up to 63, with a store followed at once by a load. A wrong lane shift or mask would corrupt neighbouring bytes. Whole-word reads after the sweeps expose this even when the narrow read-back happens to agree.

A CAS sweep mixes matches and mismatches and deliberately feeds misleading size fields. A design that wrote on a mismatch, reported the wrong observed value, or honoured `req_size` for a CAS would diverge from the byte-level model.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_CAS   = 2'd2,
        OP_RSVD  = 2'd3
    } mem_op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } mem_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/wmc_check.sv
// Legality check: natural alignment, byte-capacity bound, reserved opcode.
module wmc_check #(
    parameter int BYTE_CAP = 4096,
    parameter int ADDR_W   = 12
) (
    input  logic [1:0]        op,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        eff_size,
    output logic              fault
);
    import wmc_pkg::*;

    localparam int EXT_W = ADDR_W + 1;

    logic [3:0]       nbytes;
    logic             misalign;
    logic [EXT_W-1:0] end_addr;
    logic             oob;

    always_comb begin
        // a CAS is always a 32-bit access regardless of the size field
        eff_size = (op == OP_CAS) ? SZ_W : size;
        nbytes   = 4'd1 << eff_size;
        unique case (eff_size)
            SZ_B:    misalign = 1'b0;
            SZ_H:    misalign = addr[0];
            SZ_W:    misalign = |addr[1:0];
            default: misalign = |addr[2:0];
        endcase
        end_addr = {1'b0, addr} + EXT_W'(nbytes);
        oob      = end_addr > EXT_W'(BYTE_CAP);
        fault    = misalign | oob | (op == OP_RSVD);
    end

endmodule

// File: rtl/wmc_lane.sv
// Lane placement inside a 64-bit word for a given access size.
module wmc_lane (
    input  logic [1:0]  eff_size,
    input  logic [2:0]  addr_lo,
    output logic [5:0]  shift,
    output logic [63:0] width_mask,
    output logic [63:0] lane_mask
);
    import wmc_pkg::*;

    always_comb begin
        unique case (eff_size)
            SZ_B: begin
                shift      = {addr_lo, 3'b000};
                width_mask = 64'h0000_0000_0000_00FF;
            end
            SZ_H: begin
                shift      = {addr_lo[2:1], 4'b0000};
                width_mask = 64'h0000_0000_0000_FFFF;
            end
            SZ_W: begin
                shift      = {addr_lo[2], 5'b00000};
                width_mask = 64'h0000_0000_FFFF_FFFF;
            end
            default: begin
                shift      = 6'd0;
                width_mask = '1;
            end
        endcase
        lane_mask = width_mask << shift;
    end

endmodule

// File: rtl/wmc_array.sv
// Word storage: combinational read, one synchronous write, zero on reset.
module wmc_array #(
    parameter int WORDS = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_word,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_word
);
    localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [63:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx[SEL_W-1:0]] <= wr_word;
        end
    end

    always_comb begin
        if (32'(rd_idx) < 32'(WORDS)) begin
            rd_word = mem[rd_idx[SEL_W-1:0]];
        end else begin
            rd_word = '0;
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < 32'(WORDS))) else $error("write outside array"); // R4

endmodule

// File: rtl/word_mem_cas.sv
module word_mem_cas #(
    parameter int BYTE_CAP = 4096,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [31:0]       req_expect,
    input  logic [31:0]       req_desired,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_ok,
    output logic [31:0]       rsp_observed,
    output logic              rsp_fault
);
    import wmc_pkg::*;

    localparam int WORDS = (BYTE_CAP + 7) / 8;
    localparam int IDX_W = ADDR_W - 3;

    rsp_state_e       state_q, state_d;
    logic [1:0]       eff_size;
    logic             fault;
    logic [5:0]       shift;
    logic [63:0]      width_mask, lane_mask;
    logic [IDX_W-1:0] word_idx;
    logic [63:0]      cur_word, slot, new_word;
    logic [31:0]      cas_cur;
    logic             cas_hit, wr_en, is_load, is_store, is_cas;

    wmc_check #(.BYTE_CAP(BYTE_CAP), .ADDR_W(ADDR_W)) u_check (
        .op(req_op), .size(req_size), .addr(req_addr),
        .eff_size(eff_size), .fault(fault)
    );

    wmc_lane u_lane (
        .eff_size(eff_size), .addr_lo(req_addr[2:0]),
        .shift(shift), .width_mask(width_mask), .lane_mask(lane_mask)
    );

    wmc_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(word_idx), .rd_word(cur_word),
        .wr_en(wr_en), .wr_idx(word_idx), .wr_word(new_word)
    );

    // read-modify-write datapath, all inside the request cycle
    always_comb begin
        word_idx = req_addr[ADDR_W-1:3];
        is_load  = (req_op == OP_LOAD);
        is_store = (req_op == OP_STORE);
        is_cas   = (req_op == OP_CAS);
        slot     = cur_word >> shift;
        cas_cur  = slot[31:0];
        cas_hit  = (cas_cur == req_expect);
        if (is_cas) begin
            new_word = (cur_word & ~lane_mask) | ({32'b0, req_desired} << shift);
        end else begin
            new_word = (cur_word & ~lane_mask) | ((req_wdata & width_mask) << shift);
        end
        wr_en = req_valid && !fault && (is_store || (is_cas && cas_hit));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;  // accept / rest
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;  // stream / drain
            default: state_d = ST_IDLE;
        endcase
    end

    assign rsp_valid = (state_q == ST_RESP);

    // registered answer fields
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_rdata    <= '0;
            rsp_ok       <= 1'b0;
            rsp_observed <= '0;
            rsp_fault    <= 1'b0;
        end else begin
            rsp_fault    <= fault;
            rsp_ok       <= !fault && (is_load || is_store || (is_cas && cas_hit));
            rsp_rdata    <= (!fault && is_load) ? (slot & width_mask) : '0;
            rsp_observed <= (!fault && is_cas) ? cas_cur : '0;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing answer"); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("answer without request"); // R10

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_ok && rsp_rdata == '0 && rsp_observed == '0))
        else $error("fault with data"); // R5

    AST_CAS_WIN_OBSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && $past(req_op) == OP_CAS) |-> (rsp_observed == $past(req_expect)))
        else $error("CAS success observed mismatch"); // R8

endmodule

// File: tb/sim_word_mem_cas.sv
`timescale 1ns/1ps
module sim_word_mem_cas;

    localparam int CAP  = 52;
    localparam int AW   = 7;
    localparam int PADB = ((CAP + 7) / 8) * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [31:0] req_expect = '0;
    logic [31:0] req_desired = '0;
    logic        rsp_valid, rsp_ok, rsp_fault;
    logic [63:0] rsp_rdata;
    logic [31:0] rsp_observed;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] ref_mem [PADB];

    always #2 clk = ~clk;

    word_mem_cas #(.BYTE_CAP(CAP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_expect(req_expect), .req_desired(req_desired),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
        .rsp_observed(rsp_observed), .rsp_fault(rsp_fault)
    );

    task automatic check(input bit cond, input string tag, input logic [98:0] act, input logic [98:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input int addr, input int n);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) v = v | (64'(ref_mem[addr + i]) << (8 * i));
        return v;
    endfunction

    // one request; answer sampled at the next falling edge
    task automatic run(input int op, input int size, input int addr, input logic [63:0] wd,
                       input logic [31:0] ex, input logic [31:0] de, input string tag_in);
        int nb;
        bit misal, oob, flt, ok;
        logic [63:0] cur, rd;
        logic [31:0] obs;
        logic [98:0] expv, actv;
        string tag;
        nb    = (op == 2) ? 4 : (1 << size);
        misal = (addr % nb) != 0;
        oob   = (addr + nb) > CAP;
        flt   = (op == 3) || misal || oob;
        cur   = flt ? 64'd0 : model_read(addr, nb);
        ok = 0; rd = '0; obs = '0;
        if (!flt) begin
            if (op == 0) begin ok = 1; rd = cur; end
            if (op == 1) begin
                ok = 1;
                for (int i = 0; i < nb; i++) ref_mem[addr + i] = wd[8*i +: 8];
            end
            if (op == 2) begin
                obs = cur[31:0];
                if (cur[31:0] == ex) begin
                    ok = 1;
                    for (int i = 0; i < 4; i++) ref_mem[addr + i] = de[8*i +: 8];
                end
            end
        end
        if (tag_in != "") tag = tag_in;
        else if (op == 3) tag = "R11";
        else if (op == 2) tag = flt ? "R9" : (ok ? "R8" : "R7");
        else if (misal) tag = "R3";
        else if (oob) tag = "R4";
        else tag = (op == 1) ? "R6" : "R2";
        req_valid = 1'b1; req_op = 2'(op); req_size = 2'(size); req_addr = AW'(addr);
        req_wdata = wd; req_expect = ex; req_desired = de;
        @(negedge clk);
        expv = {1'b1, flt, ok, rd, obs};
        actv = {rsp_valid, rsp_fault, rsp_ok, rsp_rdata, rsp_observed};
        check(actv === expv, tag, actv, expv);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < PADB; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R10", 99'(rsp_valid), 99'(0));

        // R1: zero after reset, capacity edge
        for (int a = 0; a < 48; a += 8) run(0, 3, a, 0, 0, 0, "R1");
        run(0, 2, 48, 0, 0, 0, "R1");
        run(0, 0, 51, 0, 0, 0, "R1");
        run(0, 0, 52, 0, 0, 0, "R4");
        run(0, 3, 48, 0, 0, 0, "R4");

        // store/load sweep, every size and address (R2 R3 R4 R6 R10)
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 64; a++) begin
                run(1, s, a, 64'h9E37_79B9_7F4A_7C15 * 64'(a + 1) + 64'(s), 0, 0, "");
                run(0, s, a, 0, 0, 0, "");
            end
        end
        for (int a = 0; a < 48; a += 8) run(0, 3, a, 0, 0, 0, "R6");
        run(0, 2, 48, 0, 0, 0, "R6");

        // R5: faulting load with nonzero memory, faulting stores keep memory
        run(0, 3, 4, 0, 0, 0, "R5");
        run(1, 2, 50, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5");
        run(1, 0, 53, 64'hAA, 0, 0, "R5");
        run(0, 2, 48, 0, 0, 0, "R5");
        run(0, 3, 40, 0, 0, 0, "R5");

        // CAS sweep: hits and misses, misleading size field (R7 R8 R9)
        for (int a = 0; a < 64; a++) begin
            logic [31:0] cur32;
            cur32 = ((a % 4 == 0) && (a + 4 <= CAP)) ? model_read(a, 4) : 32'h0;
            if ((a / 4) % 2 == 0) run(2, a % 4, a, 0, cur32, 32'hC0DE_0000 | 32'(a), "");
            else                  run(2, a % 4, a, 0, cur32 ^ 32'h1, 32'hDEAD_0000 | 32'(a), "");
        end
        for (int a = 0; a < 48; a += 8) run(0, 3, a, 0, 0, 0, "R8");
        run(0, 2, 48, 0, 0, 0, "R7");

        // R11: reserved opcode never writes
        run(3, 3, 0, 64'h1234, 0, 0, "R11");
        run(3, 0, 8, 64'h55, 0, 0, "R11");
        run(0, 3, 0, 0, 0, 0, "R11");
        run(0, 3, 8, 0, 0, 0, "R11");

        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R10", 99'(rsp_valid), 99'(0));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule